// File: doc/BRIEF.md
# Sensor Register Bank with Latched Interrupts

This block is the register file that a serial slave front end reads and writes on behalf of a three-axis sensing core. The core pushes a new set of 10-bit two's complement samples with a single load strobe. It also raises one-cycle level and pulse detection events for each axis. The front end reaches the bank through a byte-wide port, with one read strobe and one write strobe per byte and a 5-bit register address.

A 10-bit sample is read as two bytes. Reading the low byte freezes the upper sample bits for that axis. A later read of the high byte then returns bits that belong with the low byte already taken, even if the core has loaded new samples in between. Detection events are sticky, and they drive two interrupt lines: level events drive one line and pulse events drive the other. Each line, together with its flags, is released only by a write to a clear register. A ready flag and an overrun flag report sample flow. A set of configuration bytes provides a device address, a disable bit for the two-wire bus and a 3-wire serial select.

Top module: `sensor_regbank`

## Requirements
- R1: While reset is held and right after it, bus_rdata, irq1, irq2, dev_addr, i2c_off and spi_3wire are all zero, and every register reads as zero.
- R2: A read of address 0x00, 0x02 or 0x04 returns bits [7:0] of the X, Y or Z sample on bus_rdata in the cycle after the read strobe. The read sees the value as it stood when the strobe was sampled.
- R3: A read of a low sample byte captures that axis's bits [9:8]. A read of 0x01, 0x03 or 0x05 returns the captured bits in [1:0], with [7:2] zero, whatever has been loaded since.
- R4: Addresses 0x06, 0x07 and 0x08 return bits [7:0] of the current X, Y and Z samples.
- R5: Status (0x09) bit 0 is data-ready. A sample load sets it. A read of any address from 0x00 to 0x08 clears it, and a load in the same cycle wins.
- R6: Status bit 1 is overrun. It is set by a load that arrives while data-ready is set, and cleared by a read of 0x09. That read returns the value before clearing, and a set in the same cycle wins.
- R7: Status bit 2 returns the level of parity_err at the time of the read, and status bits [7:3] read zero.
- R8: Register 0x0A reads {LX,LY,LZ,PX,PY,PZ,irq2,irq1} from bit 7 down to bit 0. The L and P bits are sticky flags set by lvl_evt[0..2] and pls_evt[0..2], where index 0 is X.
- R9: irq1 is high while any level flag is set, and irq2 is high while any pulse flag is set. Both stay high after the event inputs fall.
- R10: A write of 0x17 with bit 0 set clears the level flags and irq1. A write of 0x17 with bit 1 set clears the pulse flags and irq2. An event in the same cycle keeps its flag set, and 0x17 reads zero.
- R11: Addresses 0x0D to 0x16 and 0x18 to 0x1E read back the last byte written. dev_addr is bits [6:0] of 0x0D, i2c_off is bit 7 of 0x0D, and spi_3wire is bit 5 of 0x16.
- R12: Writes to 0x00 to 0x0C and to 0x1F change no register, and 0x0B, 0x0C and 0x1F read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Byte write strobe from the front end |
| bus_rd | input | 1 | Byte read strobe from the front end |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered, valid the cycle after bus_rd |
| smp_load | input | 1 | Load strobe for a new sample set |
| smp_x | input | 10 | X sample, two's complement |
| smp_y | input | 10 | Y sample, two's complement |
| smp_z | input | 10 | Z sample, two's complement |
| parity_err | input | 1 | Parity error level from the core |
| lvl_evt | input | 3 | Level detection events, [0]=X, [1]=Y, [2]=Z |
| pls_evt | input | 3 | Pulse detection events, [0]=X, [1]=Y, [2]=Z |
| irq1 | output | 1 | Latched level interrupt |
| irq2 | output | 1 | Latched pulse interrupt |
| dev_addr | output | 7 | Configured device address |
| i2c_off | output | 1 | Disable bit for the two-wire bus |
| spi_3wire | output | 1 | 3-wire serial select |

## Verification
Sample reads are tried with negative, positive and zero values. A new load is placed between a low and a high read, which separates a held high byte from a live one. Back-to-back loads without a read, followed by two status reads, show whether overrun sets on the right condition and clears on the read. Events are raised on several axes, cleared per line, and cleared in the same cycle as a fresh event, to show which flags belong to which line and which side wins. Every writable and read-only address is written with a distinct pattern and read back, which shows what storage exists and which writes are ignored.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
   localparam int NAX    = 3;      // axes: X, Y, Z
   localparam int A_LOW0 = 'h00;   // low/high pairs start here
   localparam int A_B8   = 'h06;   // 8-bit views
   localparam int A_STAT = 'h09;
   localparam int A_DET  = 'h0A;
   localparam int A_CFG0 = 'h0D;
   localparam int A_CLR  = 'h17;
   localparam int A_CFGN = 'h1E;
   localparam int A_MODE = 'h16;
   localparam int B_3W   = 5;

   typedef struct packed {
      logic ovr;
      logic rdy;
   } flow_t;
endpackage

// File: rtl/sreg_sample_store.sv
module sreg_sample_store #(
   parameter int NAX    = 3,
   parameter int SMP_W  = 10,
   parameter int DATA_W = 8,
   localparam int HI_W  = SMP_W - DATA_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load,
   input  logic [NAX*SMP_W-1:0]  smp_in,
   input  logic [NAX-1:0]        cap_en,
   output logic [NAX*SMP_W-1:0]  smp_q,
   output logic [NAX*HI_W-1:0]   hold_q
);
   for (genvar a = 0; a < NAX; a++) begin : g_axis
      logic [SMP_W-1:0] s_r;
      logic [HI_W-1:0]  h_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            s_r <= '0;
            h_r <= '0;
         end else begin
            if (load)      s_r <= smp_in[a*SMP_W +: SMP_W];
            if (cap_en[a]) h_r <= s_r[SMP_W-1:DATA_W];
         end
      end
      assign smp_q[a*SMP_W +: SMP_W] = s_r;
      assign hold_q[a*HI_W +: HI_W]  = h_r;
   end
endmodule

// File: rtl/sreg_detect_latch.sv
module sreg_detect_latch #(
   parameter int NAX = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NAX-1:0] lvl_set,
   input  logic [NAX-1:0] pls_set,
   input  logic           lvl_clr,
   input  logic           pls_clr,
   output logic [NAX-1:0] lvl_q,
   output logic [NAX-1:0] pls_q,
   output logic           irq_lvl,
   output logic           irq_pls
);
   for (genvar a = 0; a < NAX; a++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lvl_q[a] <= 1'b0;
            pls_q[a] <= 1'b0;
         end else begin
            if (lvl_set[a])   lvl_q[a] <= 1'b1;
            else if (lvl_clr) lvl_q[a] <= 1'b0;
            if (pls_set[a])   pls_q[a] <= 1'b1;
            else if (pls_clr) pls_q[a] <= 1'b0;
         end
      end
   end
   assign irq_lvl = |lvl_q;
   assign irq_pls = |pls_q;
endmodule

// File: rtl/sreg_cfg_file.sv
module sreg_cfg_file #(
   parameter int ADDR_W = 5,
   parameter int DATA_W = 8,
   parameter int LO     = 'h0D,
   parameter int HI     = 'h1E,
   parameter int HOLE   = 'h17,
   localparam int NREG  = HI - LO + 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr,
   input  logic [ADDR_W-1:0]      addr,
   input  logic [DATA_W-1:0]      wdata,
   output logic [NREG*DATA_W-1:0] cfg_q
);
   for (genvar g = 0; g < NREG; g++) begin : g_reg
      if (LO + g == HOLE) begin : g_hole
         assign cfg_q[g*DATA_W +: DATA_W] = '0;
      end else begin : g_store
         logic [DATA_W-1:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                               r <= '0;
            else if (wr && addr == ADDR_W'(LO + g))   r <= wdata;
         end
         assign cfg_q[g*DATA_W +: DATA_W] = r;
      end
   end
endmodule

// File: rtl/sensor_regbank.sv
module sensor_regbank
   import sreg_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int DATA_W = 8,
   parameter int SMP_W  = 10,
   parameter int DADR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              smp_load,
   input  logic [SMP_W-1:0]  smp_x,
   input  logic [SMP_W-1:0]  smp_y,
   input  logic [SMP_W-1:0]  smp_z,
   input  logic              parity_err,
   input  logic [NAX-1:0]    lvl_evt,
   input  logic [NAX-1:0]    pls_evt,
   output logic              irq1,
   output logic              irq2,
   output logic [DADR_W-1:0] dev_addr,
   output logic              i2c_off,
   output logic              spi_3wire
);
   localparam int HI_W = SMP_W - DATA_W;
   localparam int NCFG = A_CFGN - A_CFG0 + 1;

   if (DATA_W != 8) begin : g_bad_dw
      $error("sensor_regbank: DATA_W must be 8");
   end
   if (SMP_W <= DATA_W || SMP_W > 2*DATA_W) begin : g_bad_sw
      $error("sensor_regbank: SMP_W must lie in (DATA_W, 2*DATA_W]");
   end
   if ((1 << ADDR_W) <= A_CFGN + 1) begin : g_bad_aw
      $error("sensor_regbank: ADDR_W too narrow for the map");
   end
   if (DADR_W >= DATA_W) begin : g_bad_da
      $error("sensor_regbank: DADR_W must leave room for the disable bit");
   end

   logic [NAX*SMP_W-1:0]  smp_q;
   logic [NAX*HI_W-1:0]   hold_q;
   logic [NAX-1:0]        cap_en;
   logic [NAX-1:0]        lvl_q, pls_q;
   logic [NCFG*DATA_W-1:0] cfg_q;
   logic                  lvl_clr, pls_clr;
   logic                  rd_smp, rd_stat;
   flow_t                 flow_q;
   logic [DATA_W-1:0]     rd_val;

   for (genvar a = 0; a < NAX; a++) begin : g_cap
      assign cap_en[a] = bus_rd && bus_addr == ADDR_W'(A_LOW0 + 2*a);
   end

   sreg_sample_store #(.NAX(NAX), .SMP_W(SMP_W), .DATA_W(DATA_W)) u_store (
      .clk(clk), .rst_n(rst_n), .load(smp_load),
      .smp_in({smp_z, smp_y, smp_x}), .cap_en(cap_en),
      .smp_q(smp_q), .hold_q(hold_q)
   );

   assign lvl_clr = bus_wr && bus_addr == ADDR_W'(A_CLR) && bus_wdata[0];
   assign pls_clr = bus_wr && bus_addr == ADDR_W'(A_CLR) && bus_wdata[1];

   sreg_detect_latch #(.NAX(NAX)) u_det (
      .clk(clk), .rst_n(rst_n), .lvl_set(lvl_evt), .pls_set(pls_evt),
      .lvl_clr(lvl_clr), .pls_clr(pls_clr), .lvl_q(lvl_q), .pls_q(pls_q),
      .irq_lvl(irq1), .irq_pls(irq2)
   );

   sreg_cfg_file #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LO(A_CFG0),
                   .HI(A_CFGN), .HOLE(A_CLR)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
      .wdata(bus_wdata), .cfg_q(cfg_q)
   );

   // data-ready / overrun
   assign rd_smp  = bus_rd && bus_addr < ADDR_W'(A_STAT);
   assign rd_stat = bus_rd && bus_addr == ADDR_W'(A_STAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flow_q <= '0;
      end else begin
         if (smp_load)     flow_q.rdy <= 1'b1;
         else if (rd_smp)  flow_q.rdy <= 1'b0;
         if (smp_load && flow_q.rdy) flow_q.ovr <= 1'b1;
         else if (rd_stat)           flow_q.ovr <= 1'b0;
      end
   end

   // read selection
   always_comb begin
      rd_val = '0;
      for (int a = 0; a < NAX; a++) begin
         if (bus_addr == ADDR_W'(A_LOW0 + 2*a))
            rd_val = smp_q[a*SMP_W +: DATA_W];
         if (bus_addr == ADDR_W'(A_LOW0 + 2*a + 1))
            rd_val = DATA_W'(hold_q[a*HI_W +: HI_W]);
         if (bus_addr == ADDR_W'(A_B8 + a))
            rd_val = smp_q[a*SMP_W +: DATA_W];
      end
      if (bus_addr == ADDR_W'(A_STAT))
         rd_val = DATA_W'({parity_err, flow_q.ovr, flow_q.rdy});
      if (bus_addr == ADDR_W'(A_DET))
         rd_val = {lvl_q[0], lvl_q[1], lvl_q[2], pls_q[0], pls_q[1], pls_q[2],
                   irq2, irq1};
      for (int c = 0; c < NCFG; c++) begin
         if (bus_addr == ADDR_W'(A_CFG0 + c))
            rd_val = cfg_q[c*DATA_W +: DATA_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_val;
   end

   assign dev_addr  = cfg_q[0 +: DADR_W];
   assign i2c_off   = cfg_q[DATA_W-1];
   assign spi_3wire = cfg_q[(A_MODE - A_CFG0)*DATA_W + B_3W];
endmodule

// File: rtl/sreg_chk.sv
module sreg_chk #(
   parameter int ADDR_W = 5,
   parameter int DATA_W = 8,
   parameter int DADR_W = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [2:0]        lvl_evt,
   input logic [2:0]        pls_evt,
   input logic              irq1,
   input logic              irq2,
   input logic [DADR_W-1:0] dev_addr
);
   logic clr1, clr2;
   assign clr1 = bus_wr && bus_addr == ADDR_W'('h17) && bus_wdata[0];
   assign clr2 = bus_wr && bus_addr == ADDR_W'('h17) && bus_wdata[1];

   p_lvl_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (|lvl_evt) |=> irq1);
   p_pls_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (|pls_evt) |=> irq2);
   p_irq1_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq1 && !clr1) |=> irq1);
   p_irq2_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq2 && !clr2) |=> irq2);
   p_clr1_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (clr1 && !(|lvl_evt)) |=> !irq1);
   p_clr2_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (clr2 && !(|pls_evt)) |=> !irq2);
   p_hi_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && (bus_addr == ADDR_W'(1) || bus_addr == ADDR_W'(3) ||
                  bus_addr == ADDR_W'(5))) |=> bus_rdata[DATA_W-1:2] == '0);
   p_reserved_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && (bus_addr == ADDR_W'('h1F) || bus_addr == ADDR_W'('h0C)))
      |=> bus_rdata == '0);
   p_devaddr_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'('h0D)) |=> dev_addr == $past(bus_wdata[DADR_W-1:0]));
   p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));
endmodule

bind sensor_regbank sreg_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DADR_W(DADR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .lvl_evt(lvl_evt), .pls_evt(pls_evt), .irq1(irq1), .irq2(irq2),
   .dev_addr(dev_addr)
);

// File: tb/sensor_regbank_tb.sv
module sensor_regbank_tb;
   localparam int CLK_PER = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [4:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       smp_load = 1'b0;
   logic [9:0] smp_x = '0, smp_y = '0, smp_z = '0;
   logic       parity_err = 1'b0;
   logic [2:0] lvl_evt = '0, pls_evt = '0;
   logic       irq1, irq2, i2c_off, spi_3wire;
   logic [6:0] dev_addr;

   int n_cmp = 0, n_bad = 0;
   bit finished = 0;

   sensor_regbank u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .smp_load(smp_load), .smp_x(smp_x), .smp_y(smp_y), .smp_z(smp_z),
      .parity_err(parity_err), .lvl_evt(lvl_evt), .pls_evt(pls_evt),
      .irq1(irq1), .irq2(irq2), .dev_addr(dev_addr), .i2c_off(i2c_off),
      .spi_3wire(spi_3wire)
   );

   always #(CLK_PER/2) clk = ~clk;

   // ---------------- behavioural reference ----------------
   int m_smp[3], m_hold[3], m_lvl[3], m_pls[3], m_cfg[32];
   int m_rdy, m_ovr, m_rdata, m_last;

   function automatic int m_read(int a);
      if (a <= 5)  return (a % 2 == 0) ? (m_smp[a/2] & 'hFF) : m_hold[a/2];
      if (a <= 8)  return m_smp[a-6] & 'hFF;
      if (a == 9)  return (int'(parity_err) << 2) | (m_ovr << 1) | m_rdy;
      if (a == 10) return (m_lvl[0] << 7) | (m_lvl[1] << 6) | (m_lvl[2] << 5) |
                          (m_pls[0] << 4) | (m_pls[1] << 3) | (m_pls[2] << 2) |
                          ((m_pls[0] | m_pls[1] | m_pls[2]) << 1) |
                          (m_lvl[0] | m_lvl[1] | m_lvl[2]);
      if (a >= 'h0D && a <= 'h1E) return m_cfg[a];
      return 0;
   endfunction

   function automatic string tag_of(int a);
      if (a <= 5 && a % 2 == 0) return "R2";
      if (a <= 5)  return "R3";
      if (a <= 8)  return "R4";
      if (a == 9)  return "R5 R6 R7";
      if (a == 10) return "R8";
      if (a == 'h17) return "R10";
      if (a >= 'h0D && a <= 'h1E) return "R11";
      return "R12";
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 3; i++) begin
            m_smp[i] = 0; m_hold[i] = 0; m_lvl[i] = 0; m_pls[i] = 0;
         end
         for (int i = 0; i < 32; i++) m_cfg[i] = 0;
         m_rdy = 0; m_ovr = 0; m_rdata = 0; m_last = 0;
      end else begin
         automatic int a = int'(bus_addr);
         automatic int ovr_new = (smp_load && m_rdy) ? 1 : 0;
         if (bus_rd) begin
            m_rdata = m_read(a);
            m_last = a;
            if (a <= 4 && a % 2 == 0) m_hold[a/2] = m_smp[a/2] >> 8;
         end
         if (smp_load) m_rdy = 1;
         else if (bus_rd && a <= 8) m_rdy = 0;
         if (ovr_new == 1) m_ovr = 1;
         else if (bus_rd && a == 9) m_ovr = 0;
         if (smp_load) begin
            m_smp[0] = int'(smp_x); m_smp[1] = int'(smp_y); m_smp[2] = int'(smp_z);
         end
         for (int i = 0; i < 3; i++) begin
            if (bus_wr && a == 'h17 && bus_wdata[0]) m_lvl[i] = 0;
            if (bus_wr && a == 'h17 && bus_wdata[1]) m_pls[i] = 0;
            if (lvl_evt[i]) m_lvl[i] = 1;
            if (pls_evt[i]) m_pls[i] = 1;
         end
         if (bus_wr && a >= 'h0D && a <= 'h1E && a != 'h17) m_cfg[a] = int'(bus_wdata);
      end
   end

   task automatic check(string req, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   // compare every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         check(tag_of(m_last), int'(bus_rdata), m_rdata);
         check("R9 irq1", int'(irq1), m_lvl[0] | m_lvl[1] | m_lvl[2]);
         check("R9 irq2", int'(irq2), m_pls[0] | m_pls[1] | m_pls[2]);
         check("R11 dev_addr", int'(dev_addr), m_cfg['h0D] & 'h7F);
         check("R11 i2c_off", int'(i2c_off), (m_cfg['h0D] >> 7) & 1);
         check("R11 spi_3wire", int'(spi_3wire), (m_cfg['h16] >> 5) & 1);
      end
   end

   // ---------------- stimulus ----------------
   task automatic rd(int a);
      @(negedge clk); bus_rd = 1'b1; bus_addr = 5'(a);
      @(negedge clk); bus_rd = 1'b0;
   endtask

   task automatic wr(int a, int d);
      @(negedge clk); bus_wr = 1'b1; bus_addr = 5'(a); bus_wdata = 8'(d);
      @(negedge clk); bus_wr = 1'b0;
   endtask

   task automatic ld(int x, int y, int z);
      @(negedge clk); smp_load = 1'b1; smp_x = 10'(x); smp_y = 10'(y); smp_z = 10'(z);
      @(negedge clk); smp_load = 1'b0;
   endtask

   task automatic evt(int l, int p);
      @(negedge clk); lvl_evt = 3'(l); pls_evt = 3'(p);
      @(negedge clk); lvl_evt = '0; pls_evt = '0;
   endtask

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1 rdata", int'(bus_rdata), 0);
      check("R1 irq1", int'(irq1), 0);
      check("R1 irq2", int'(irq2), 0);
      check("R1 dev_addr", int'(dev_addr), 0);
      check("R1 spi_3wire", int'(spi_3wire), 0);
      rst_n = 1'b1;
      for (int a = 0; a < 32; a++) rd(a);          // R1: all read zero

      // R2 R4 R5: negative, positive, zero samples
      ld('h2A5, 'h17F, 'h000);
      rd(9);                                        // R5 ready
      rd(0); rd(9);                                 // R5 cleared by sample read
      ld('h155, 'h200, 'h3FF);                      // new load between low and high
      rd(1);                                        // R3 held 0x2
      rd(0); rd(1);                                 // R3 now 0x1
      rd(2); rd(3); rd(4); rd(5);
      rd(6); rd(7); rd(8);                          // R4

      // R6 overrun
      ld(1, 2, 3); ld(4, 5, 6);
      rd(9); rd(9);
      // R7 parity level
      parity_err = 1'b1; rd(9); parity_err = 1'b0; rd(9);
      // R5: load and sample read in same cycle, load wins
      @(negedge clk); smp_load = 1'b1; smp_x = 10'h0F0; bus_rd = 1'b1; bus_addr = 5'd0;
      @(negedge clk); smp_load = 1'b0; bus_rd = 1'b0;
      rd(9); rd(0);

      // R8 R9 R10 detection
      evt(1, 0); repeat (3) @(negedge clk); rd(10);
      evt(0, 4); rd(10);
      evt(2, 2); rd(10);
      wr('h17, 1); rd(10);                          // R10 level clear
      @(negedge clk); bus_wr = 1'b1; bus_addr = 5'h17; bus_wdata = 8'h02; pls_evt = 3'b001;
      @(negedge clk); bus_wr = 1'b0; pls_evt = '0;  // R10 event wins
      rd(10);
      wr('h17, 3); rd(10); rd('h17);

      // R11 config
      wr('h0D, 'hBA); wr('h16, 'h20);
      for (int a = 'h0D; a <= 'h1E; a++) wr(a, (a * 37 + 5) & 'hFF);
      for (int a = 'h0D; a <= 'h1E; a++) rd(a);
      // R12 ignored writes
      for (int a = 0; a <= 'h0C; a++) wr(a, 'hFF);
      wr('h1F, 'hFF);
      for (int a = 0; a <= 'h0C; a++) rd(a);
      rd('h1F);

      repeat (3) @(negedge clk);
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule